// File: doc/BRIEF.md
# Serial Port Command and Status Controller

This block sits between a register bus and the datapath of a serial port. Software writes command words in which each bit is a one-shot request. The block turns these requests into five persistent control flags and two one-cycle flush strobes. The flags are transmitter on, receiver on, transmit output released (high impedance), master mode and receive block. The flush strobes empty the transmit and receive buffers together with their shift registers. A status read port returns the flags and a sticky error bit.

The block also watches the frame events that the receiver reports: frame started and frame finished. For each frame it decides whether the data is loaded into the receive buffer or thrown away. A small state machine with the states RX_OFF, RX_IDLE and RX_BUSY makes this decision. Its transitions are:

- RX_OFF to RX_IDLE when the receiver flag is set.
- RX_IDLE to RX_BUSY on a frame start, unless a receive flush is active in the same cycle.
- RX_BUSY to RX_IDLE on frame end or on a receive flush.
- RX_IDLE or RX_BUSY to RX_OFF when the receiver flag clears. Leaving RX_BUSY this way discards the partial frame.

Command word layout: for pair k, bit 2k sets the flag and bit 2k+1 clears it. The pairs are k=0 transmitter, k=1 receiver, k=2 transmit high impedance, k=3 master and k=4 receive block. Bit 10 requests a transmit flush and bit 11 a receive flush.

Top module: `sercmd_ctrl`

## Requirements
- R1: After reset all five flags, the error bit, tx_flush, rx_flush, rx_load and rx_discard are 0, tx_drive_en is 1, and a read of the status address returns 0.
- R2: A write to CMD_OFFSET changes a flag at the next clock edge only through a 1 in one of its two bits. For pair k, bit 2k sets the flag and bit 2k+1 clears it. Pair 0 is the transmitter, 1 the receiver, 2 transmit high impedance, 3 master and 4 receive block. Bits written as 0, and writes to any other address, leave every flag unchanged.
- R3: When one write sets both bits of a pair, the flag ends cleared.
- R4: A write with bit 10 set drives tx_flush high for exactly the cycle after the write. A write with bit 11 set does the same for rx_flush. A 0 in these bits produces no strobe.
- R5: tx_drive_en is the inverse of the transmit high-impedance flag.
- R6: A master set request (bit 6) that arrives while the transmitter flag is already 1 is ignored and sets the sticky error bit. The error bit stays set until reset. Setting master before the transmitter, or in the same write, is accepted with no error.
- R7: A read of STAT_OFFSET returns the flags in bits 0 to 4, in pair order, and the error bit in bit 5, with all other bits 0. A read of CMD_OFFSET, or of any other address, returns 0.
- R8: A frame that ends while the receiver is on and receive block is 0 gives a one-cycle rx_load pulse in the cycle after frm_end. With receive block set, the same frame gives an rx_discard pulse instead. rx_load and rx_discard are never high together.
- R9: If the receiver flag clears while a frame is in progress, rx_discard pulses once. A later frm_end for that frame produces no strobe.
- R10: A receive flush during a frame discards the frame through an rx_discard pulse. The next frame after that is handled normally.
- R11: While the receiver flag is 0, frm_start and frm_end produce neither rx_load nor rx_discard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 12 | Command word |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational |
| frm_start | input | 1 | Receiver reports a frame start |
| frm_end | input | 1 | Receiver reports a completed frame |
| tx_enable | output | 1 | Transmitter flag |
| rx_enable | output | 1 | Receiver flag |
| master_mode | output | 1 | Master flag (0 means slave) |
| tx_drive_en | output | 1 | Transmit output is driven |
| tx_flush | output | 1 | Empty the transmit buffer and shift register |
| rx_flush | output | 1 | Empty the receive buffer and shift register |
| rx_load | output | 1 | Load the finished frame into the receive buffer |
| rx_discard | output | 1 | Drop the current frame |

## Verification
The bench builds the block with its default parameters: 8-bit addresses, 32-bit read data and the command and status registers at 0x0C and 0x10. Because the command word is only 12 bits wide, the bench can sweep all 4096 words in sequence. Each word acts on the state that the previous word left behind. This covers every set/clear collision, every master and transmitter ordering, and every flush combination. Directed frame sequences then drive the receive state machine through each of its transitions: disable during a frame, flush during a frame, blocked frames and ignored frames.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
    localparam int NPAIR  = 5;
    localparam int CMD_W  = 2 * NPAIR + 2;
    localparam int F_TX   = 0;
    localparam int F_RX   = 1;
    localparam int F_TRI  = 2;
    localparam int F_MST  = 3;
    localparam int F_BLK  = 4;
    localparam int B_TXFL = 2 * NPAIR;
    localparam int B_RXFL = 2 * NPAIR + 1;
    localparam int ERR_POS = NPAIR;

    typedef enum logic [1:0] {
        RX_OFF  = 2'd0,
        RX_IDLE = 2'd1,
        RX_BUSY = 2'd2
    } rx_state_e;
endpackage

// File: rtl/sercmd_decode.sv
module sercmd_decode
    import sercmd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CMD_OFFSET = 8'h0C
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CMD_W-1:0]  wr_data,
    input  logic              tx_on,
    output logic              hit,
    output logic [NPAIR-1:0]  set_req,
    output logic [NPAIR-1:0]  clr_req,
    output logic              txfl_req,
    output logic              rxfl_req,
    output logic              err_req
);
    assign hit = wr_en && (wr_addr == CMD_OFFSET);

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        assign clr_req[k] = hit && wr_data[2*k+1];
        if (k == F_MST) begin : g_guard
            // master may not start while the transmitter already runs
            assign set_req[k] = hit && wr_data[2*k] && !tx_on;
        end else begin : g_plain
            assign set_req[k] = hit && wr_data[2*k];
        end
    end

    assign err_req  = hit && wr_data[2*F_MST] && tx_on;
    assign txfl_req = hit && wr_data[B_TXFL];
    assign rxfl_req = hit && wr_data[B_RXFL];
endmodule

// File: rtl/sercmd_flags.sv
module sercmd_flags
    import sercmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPAIR-1:0] set_req,
    input  logic [NPAIR-1:0] clr_req,
    input  logic             err_req,
    input  logic             txfl_req,
    input  logic             rxfl_req,
    output logic [NPAIR-1:0] flag_q,
    output logic             err_q,
    output logic             tx_flush,
    output logic             rx_flush
);
    for (genvar k = 0; k < NPAIR; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q[k] <= 1'b0;
            else if (clr_req[k]) flag_q[k] <= 1'b0;
            else if (set_req[k]) flag_q[k] <= 1'b1;
        end

        // R3: a clear request always leaves the flag at 0
        a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            clr_req[k] |=> !flag_q[k]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q    <= 1'b0;
            tx_flush <= 1'b0;
            rx_flush <= 1'b0;
        end else begin
            if (err_req) err_q <= 1'b1;
            tx_flush <= txfl_req;
            rx_flush <= rxfl_req;
        end
    end

    // R6: the error bit is sticky
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(err_q));
endmodule

// File: rtl/sercmd_rxfsm.sv
module sercmd_rxfsm
    import sercmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_on,
    input  logic rx_block,
    input  logic rx_flush,
    input  logic frm_start,
    input  logic frm_end,
    output logic rx_load,
    output logic rx_discard
);
    rx_state_e state, nxt;
    logic      load_d, disc_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt    = state;
        load_d = 1'b0;
        disc_d = 1'b0;
        unique case (state)
            RX_OFF: begin
                if (rx_on) nxt = RX_IDLE;
            end
            RX_IDLE: begin
                if (!rx_on)                      nxt = RX_OFF;
                else if (frm_start && !rx_flush) nxt = RX_BUSY;
            end
            RX_BUSY: begin
                if (!rx_on) begin
                    nxt    = RX_OFF;
                    disc_d = 1'b1;
                end else if (rx_flush) begin
                    nxt    = RX_IDLE;
                    disc_d = 1'b1;
                end else if (frm_end) begin
                    nxt    = RX_IDLE;
                    load_d = !rx_block;
                    disc_d = rx_block;
                end
            end
            default: nxt = RX_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_load    <= 1'b0;
            rx_discard <= 1'b0;
        end else begin
            rx_load    <= load_d;
            rx_discard <= disc_d;
        end
    end

    // R8: never both strobes
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_load && rx_discard));
    // R8: a load only follows a cycle with the block flag clear
    a_r8_load_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |-> !$past(rx_block));
    // R9: disabling during a frame discards it
    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_BUSY && !rx_on) |=> rx_discard);
    // R10: a flush during a frame ends the frame
    a_r10_flush_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_BUSY && rx_flush) |=> state != RX_BUSY);
endmodule

// File: rtl/sercmd_ctrl.sv
module sercmd_ctrl
    import sercmd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CMD_OFFSET  = 8'h0C,
    parameter logic [ADDR_W-1:0] STAT_OFFSET = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CMD_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              frm_start,
    input  logic              frm_end,
    output logic              tx_enable,
    output logic              rx_enable,
    output logic              master_mode,
    output logic              tx_drive_en,
    output logic              tx_flush,
    output logic              rx_flush,
    output logic              rx_load,
    output logic              rx_discard
);
    logic             hit;
    logic [NPAIR-1:0] set_req, clr_req, flag_q;
    logic             err_req, txfl_req, rxfl_req, err_q;

    sercmd_decode #(.ADDR_W(ADDR_W), .CMD_OFFSET(CMD_OFFSET)) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tx_on(flag_q[F_TX]), .hit(hit), .set_req(set_req),
        .clr_req(clr_req), .txfl_req(txfl_req), .rxfl_req(rxfl_req),
        .err_req(err_req)
    );

    sercmd_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req),
        .err_req(err_req), .txfl_req(txfl_req), .rxfl_req(rxfl_req),
        .flag_q(flag_q), .err_q(err_q), .tx_flush(tx_flush),
        .rx_flush(rx_flush)
    );

    sercmd_rxfsm u_rx (
        .clk(clk), .rst_n(rst_n), .rx_on(flag_q[F_RX]),
        .rx_block(flag_q[F_BLK]), .rx_flush(rx_flush),
        .frm_start(frm_start), .frm_end(frm_end),
        .rx_load(rx_load), .rx_discard(rx_discard)
    );

    assign tx_enable   = flag_q[F_TX];
    assign rx_enable   = flag_q[F_RX];
    assign master_mode = flag_q[F_MST];
    assign tx_drive_en = !flag_q[F_TRI];

    always_comb begin
        rd_data = '0;
        if (rd_addr == STAT_OFFSET) begin
            rd_data[NPAIR-1:0] = flag_q;
            rd_data[ERR_POS]   = err_q;
        end
    end

    // R6: master never rises while the transmitter was already on
    a_r6_master_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master_mode) |-> !$past(tx_enable));
    // R4: a transmit flush strobe is always caused by a command write
    a_r4_txflush_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |-> $past(hit && wr_data[B_TXFL]));
    // R4: a receive flush strobe is always caused by a command write
    a_r4_rxflush_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |-> $past(hit && wr_data[B_RXFL]));
    // R3: both receiver bits in one write leave the receiver off
    a_r3_rx_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_data[2*F_RX] && wr_data[2*F_RX+1]) |=> !rx_enable);
endmodule

// File: tb/sercmd_ctrl_bench.sv
module sercmd_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] CMDA = 8'h0C;
    localparam logic [7:0] STATA = 8'h10;

    logic        clk = 0, rst_n = 0, wr_en = 0, frm_start = 0, frm_end = 0;
    logic [7:0]  wr_addr = CMDA, rd_addr = STATA;
    logic [11:0] wr_data = '0;
    logic [31:0] rd_data;
    logic tx_enable, rx_enable, master_mode, tx_drive_en;
    logic tx_flush, rx_flush, rx_load, rx_discard;
    int   total = 0, bad = 0, cycles = 0;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sercmd_ctrl u_sercmd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .frm_start(frm_start), .frm_end(frm_end), .tx_enable(tx_enable),
        .rx_enable(rx_enable), .master_mode(master_mode),
        .tx_drive_en(tx_drive_en), .tx_flush(tx_flush), .rx_flush(rx_flush),
        .rx_load(rx_load), .rx_discard(rx_discard)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic wr(logic [7:0] a, logic [11:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0; wr_data = '0;
    endtask

    task automatic pulse_start();
        @(negedge clk); frm_start = 1;
        @(negedge clk); frm_start = 0;
    endtask

    task automatic pulse_end();
        @(negedge clk); frm_end = 1;
        @(negedge clk); frm_end = 0;
    endtask

    // expected status after one command word: bits tx,rx,tri,mst,blk,err
    function automatic logic [5:0] model(logic [5:0] s, logic [11:0] w);
        logic [5:0] n = s;
        for (int k = 0; k < 5; k++) begin
            if (w[2*k+1])                        n[k] = 1'b0;
            else if (w[2*k] && !(k == 3 && s[0])) n[k] = 1'b1;
        end
        if (w[6] && s[0]) n[5] = 1'b1;
        return n;
    endfunction

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++;
                $display("FAIL watchdog act=%0d exp=<100000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [5:0] m;
        do_reset();
        #1;
        check("R1 status", rd_data, 0);
        check("R1 strobes", {tx_flush, rx_flush, rx_load, rx_discard}, 0);
        check("R1 drive", tx_drive_en, 1);
        check("R1 flags", {tx_enable, rx_enable, master_mode}, 0);

        // R2: other address ignored
        wr(8'h14, 12'hFFF);
        check("R2 other addr", rd_data, 0);
        check("R2 other addr flush", {tx_flush, rx_flush}, 0);
        // R7: command address reads zero
        wr(CMDA, 12'h001);
        rd_addr = CMDA; #1;
        check("R7 cmd reads 0", rd_data, 0);
        rd_addr = 8'h33; #1;
        check("R7 other reads 0", rd_data, 0);
        rd_addr = STATA; #1;
        check("R7 status tx", rd_data, 32'h1);
        // R6: master after transmitter rejected
        wr(CMDA, 12'h040);
        check("R6 rejected", rd_data, 32'h21);
        check("R6 master pin", master_mode, 0);
        do_reset();
        wr(CMDA, 12'h041);
        check("R6 same write legal", rd_data, 32'h09);
        do_reset();
        wr(CMDA, 12'h040); wr(CMDA, 12'h001);
        check("R6 master first legal", rd_data, 32'h09);
        // R5
        wr(CMDA, 12'h010);
        check("R5 tristate", tx_drive_en, 0);
        wr(CMDA, 12'h020);
        check("R5 drive", tx_drive_en, 1);

        // frames
        do_reset();
        pulse_start(); pulse_end();
        check("R11 off no strobe", {rx_load, rx_discard}, 0);
        @(negedge clk);
        check("R11 off no strobe late", {rx_load, rx_discard}, 0);
        wr(CMDA, 12'h004);
        pulse_start(); pulse_end();
        check("R8 load", {rx_load, rx_discard}, 2'b10);
        @(negedge clk);
        check("R8 load one cycle", rx_load, 0);
        wr(CMDA, 12'h100);
        pulse_start(); pulse_end();
        check("R8 blocked discard", {rx_load, rx_discard}, 2'b01);
        wr(CMDA, 12'h200);
        pulse_start(); pulse_end();
        check("R8 unblocked load", {rx_load, rx_discard}, 2'b10);
        // R9: disable mid-frame
        pulse_start();
        wr(CMDA, 12'h008);
        @(negedge clk);
        check("R9 abort discard", {rx_load, rx_discard}, 2'b01);
        pulse_end();
        check("R9 later end silent", {rx_load, rx_discard}, 0);
        // R10: flush mid-frame
        wr(CMDA, 12'h004);
        pulse_start();
        wr(CMDA, 12'h800);
        check("R4 rx flush", {tx_flush, rx_flush}, 2'b01);
        @(negedge clk);
        check("R10 flush discard", {rx_load, rx_discard}, 2'b01);
        check("R4 rx flush one cycle", rx_flush, 0);
        pulse_end();
        check("R10 end after flush silent", {rx_load, rx_discard}, 0);
        pulse_start(); pulse_end();
        check("R10 next frame loads", {rx_load, rx_discard}, 2'b10);

        // exhaustive sweep of command words
        do_reset();
        m = '0;
        for (int i = 0; i < 4096; i++) begin
            logic [11:0] w = 12'(i) ^ 12'(i >> 5);
            wr(CMDA, w);
            m = model(m, w);
            check("R2 R3 R6 sweep status", rd_data, {26'd0, m});
            check("R4 sweep flush", {tx_flush, rx_flush}, {w[10], w[11]});
            check("R5 sweep drive", tx_drive_en, !m[2]);
            @(negedge clk);
            check("R4 sweep flush low", {tx_flush, rx_flush}, 0);
            check("R11 sweep quiet", {rx_load, rx_discard}, 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule